// File: doc/BRIEF.md
# Dual-Scan Panel Refresh Engine

This block keeps a 640×480 dual-scan monochrome panel refreshed from an external byte-wide asynchronous SRAM. The panel is split into an upper and a lower half that are scanned at the same time, so the block drives two 4-bit data buses in parallel: one carries pixels for the upper half, the other pixels for the lower half.

Every character period lasts four cycles of the fast clock. The engine produces a shift clock, a line pulse and a frame pulse from a character counter and a line counter connected in cascade. In the first character period of every pair, it reads one byte from the upper-half region and one byte from the lower-half region of the SRAM. It then presents the high nibbles of both bytes in the next character period and the low nibbles in the period after that. The lower-half region starts at a fixed offset equal to the size of one half-screen in bytes. The read pointer therefore runs over one half-screen and wraps back to zero.

The number of characters per line and the number of lines per frame are parameters. With the defaults (160 and 240), the frame rate is the character clock divided by 38400. A 2.76 MHz character clock then gives about 72 Hz, which is above the 70 Hz floor. The address width must be large enough to hold twice the half-screen byte count. Both counts must be at least 2.

Top module: `lcd_dual_scan_refresh`

## Requirements
- R1: When reset is asserted, which acts asynchronously and is active low, the following are all zero: the counters, the holding bytes, the read pointer, `sram_addr_o`, `sram_rd_o`, `shift_clk_o`, `lp_o`, `fp_o` and both nibble buses.
- R2: A character period is four clock cycles, with phases 0 to 3. The first period begins at the first clock after reset is released. `shift_clk_o` is low in phases 0 and 1 and high in phases 2 and 3.
- R3: Periods are numbered k from 0 after reset. `lp_o` is high for exactly the whole of period k when k mod CHARS_PER_LINE equals CHARS_PER_LINE−1, and low at all other times. Each line therefore has exactly CHARS_PER_LINE periods.
- R4: `fp_o` is high only together with `lp_o`, and only in the last period of the last line of a frame. That is the period where k mod (CHARS_PER_LINE·LINES_PER_FRAME) is the maximum, so each frame has exactly LINES_PER_FRAME lines.
- R5: `sram_rd_o` is high in phases 1 and 2 of every even period k, and low at all other times. During phase 1 `sram_addr_o` is the read pointer. During phase 2 it is the read pointer plus HALF_BYTES.
- R6: In period k ≥ 1, let j = (k−1)/2 using integer division. `upper_nib_o` shows the byte read at address j (mod HALF_BYTES) and `lower_nib_o` shows the byte read at address j + HALF_BYTES. Bits [7:4] are shown when k is odd and bits [3:0] when k is even. Both buses are 0 in period 0.
- R7: The read pointer equals (k/2) mod HALF_BYTES. It advances by one per pair of periods and wraps from HALF_BYTES−1 to 0.
- R8: HALF_BYTES is CHARS_PER_LINE·LINES_PER_FRAME/2. Upper reads always fall below this offset and lower reads always fall at or above it.
- R9: If reset is asserted in the middle of a period, the outputs return at once to the R1 state. After reset is released, scanning restarts at period 0, with a fetch in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per character period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sram_addr_o | output | ADDR_W | SRAM read address |
| sram_rd_o | output | 1 | SRAM read strobe |
| sram_rdata_i | input | 8 | SRAM read data (asynchronous, valid for the current address) |
| shift_clk_o | output | 1 | Panel shift clock |
| lp_o | output | 1 | Line pulse |
| fp_o | output | 1 | Frame pulse |
| upper_nib_o | output | 4 | Upper half-panel data nibble |
| lower_nib_o | output | 4 | Lower half-panel data nibble |

## Verification
Let c be the number of rising edges since reset was released. Every result is then due at a cycle that can be computed from c alone. The shift clock, line pulse, frame pulse, strobe and address are registered, so each one shows the value for phase c mod 4 of period c/4. The nibbles lag their fetch by one full character period. The bench samples every output at each falling edge after release. It compares each sample with values computed from c and from its own SRAM image. It also checks the reset state 1 ns after an asynchronous reset assertion at a random time in the middle of a period.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  // Position inside one character period (four fast cycles)
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_UPPER = 2'd1,
    PH_LOWER = 2'd2,
    PH_SHIFT = 2'd3
  } char_phase_e;
endpackage

// File: rtl/lcd_char_phase.sv
`timescale 1ns/1ps
module lcd_char_phase
  import lcd_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output char_phase_e ph_o,
  output logic        char_tick_o,
  output logic        shift_clk_o
);
  char_phase_e ph_q, ph_d;
  logic        sclk_q, sclk_d;

  always_comb begin
    ph_d   = char_phase_e'(2'(ph_q + 2'd1));
    sclk_d = (ph_d == PH_LOWER) || (ph_d == PH_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SETUP;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign ph_o        = ph_q;
  assign char_tick_o = (ph_q == PH_SHIFT);
  assign shift_clk_o = sclk_q;

  // R2: the shift clock rises only on entry to phase 2
  p_sclk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> (ph_q == PH_LOWER));
  // R2: period boundaries are four cycles apart, never adjacent
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_tick_o |=> !char_tick_o);
endmodule

// File: rtl/lcd_scan_timing.sv
`timescale 1ns/1ps
module lcd_scan_timing #(
  parameter int CHARS_PER_LINE  = 160,
  parameter int LINES_PER_FRAME = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic char_tick_i,
  output logic lp_o,
  output logic fp_o
);
  localparam int CW = $clog2(CHARS_PER_LINE);
  localparam int LW = $clog2(LINES_PER_FRAME);
  localparam logic [CW-1:0] CHAR_LAST = CW'(CHARS_PER_LINE - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES_PER_FRAME - 1);

  logic [CW-1:0] char_q, char_d;
  logic [LW-1:0] line_q, line_d;
  logic          lp_q, lp_d, fp_q, fp_d;

  always_comb begin
    char_d = char_q;
    line_d = line_q;
    lp_d   = lp_q;
    fp_d   = fp_q;
    if (char_tick_i) begin
      if (char_q == CHAR_LAST) begin
        char_d = '0;
        line_d = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end else begin
        char_d = char_q + 1'b1;
      end
      // pulses describe the period that starts now
      lp_d = (char_d == CHAR_LAST);
      fp_d = lp_d && (line_d == LINE_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      line_q <= '0;
      lp_q   <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      char_q <= char_d;
      line_q <= line_d;
      lp_q   <= lp_d;
      fp_q   <= fp_d;
    end
  end

  assign lp_o = lp_q;
  assign fp_o = fp_q;

  // R3: line pulse only changes at a period boundary
  p_lp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !char_tick_i |=> $stable(lp_q));
  // R3: character counter stays inside the line
  p_char_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(char_q) < CHARS_PER_LINE);
  // R4: frame pulse never appears without the line pulse
  p_fp_with_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> lp_q);
  // R4: line counter stays inside the frame
  p_line_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_q) < LINES_PER_FRAME);
endmodule

// File: rtl/lcd_pair_fetch.sv
`timescale 1ns/1ps
module lcd_pair_fetch
  import lcd_scan_pkg::*;
#(
  parameter int HALF_BYTES = 19200,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  char_phase_e       ph_i,
  input  logic              char_tick_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic [NIB_W-1:0]  upper_nib_o,
  output logic [NIB_W-1:0]  lower_nib_o
);
  localparam int PW = $clog2(HALF_BYTES);
  localparam logic [PW-1:0]     PTR_LAST = PW'(HALF_BYTES - 1);
  localparam logic [ADDR_W-1:0] LOW_BASE = ADDR_W'(HALF_BYTES);

  logic              pair_odd_q, pair_odd_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic [BYTE_W-1:0] hold_up_q, hold_up_d, hold_lo_q, hold_lo_d;
  logic [NIB_W-1:0]  up_q, up_d, lo_q, lo_d;
  logic              fetching;

  assign fetching = !pair_odd_q;

  always_comb begin
    pair_odd_d = char_tick_i ? !pair_odd_q : pair_odd_q;
    ptr_d      = ptr_q;
    if (char_tick_i && fetching)
      ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

    addr_d = addr_q;
    rd_d   = 1'b0;
    if (fetching && ph_i == PH_SETUP) begin
      addr_d = ADDR_W'(ptr_q);
      rd_d   = 1'b1;
    end else if (fetching && ph_i == PH_UPPER) begin
      addr_d = ADDR_W'(ptr_q) + LOW_BASE;
      rd_d   = 1'b1;
    end

    hold_up_d = (fetching && ph_i == PH_UPPER) ? rdata_i : hold_up_q;
    hold_lo_d = (fetching && ph_i == PH_LOWER) ? rdata_i : hold_lo_q;

    up_d = up_q;
    lo_d = lo_q;
    if (ph_i == PH_SHIFT) begin
      up_d = fetching ? hold_up_q[BYTE_W-1:NIB_W] : hold_up_q[NIB_W-1:0];
      lo_d = fetching ? hold_lo_q[BYTE_W-1:NIB_W] : hold_lo_q[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_odd_q <= 1'b0;
      ptr_q      <= '0;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      hold_up_q  <= '0;
      hold_lo_q  <= '0;
      up_q       <= '0;
      lo_q       <= '0;
    end else begin
      pair_odd_q <= pair_odd_d;
      ptr_q      <= ptr_d;
      addr_q     <= addr_d;
      rd_q       <= rd_d;
      hold_up_q  <= hold_up_d;
      hold_lo_q  <= hold_lo_d;
      up_q       <= up_d;
      lo_q       <= lo_d;
    end
  end

  assign addr_o      = addr_q;
  assign rd_o        = rd_q;
  assign upper_nib_o = up_q;
  assign lower_nib_o = lo_q;

  // R5: strobe only inside the fetch period of a pair
  p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> !pair_odd_q);
  // R6: panel nibbles change only on entry to a new period
  p_nib_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_i != PH_SETUP) |-> ($stable(up_q) && $stable(lo_q)));
  // R7: pointer never leaves the half-screen region
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < HALF_BYTES);
  // R8: upper read below the lower base, lower read at or above it
  p_upper_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && ph_i == PH_UPPER) |-> (addr_q < LOW_BASE));
  p_lower_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && ph_i == PH_LOWER) |-> (addr_q >= LOW_BASE));
endmodule

// File: rtl/lcd_dual_scan_refresh.sv
`timescale 1ns/1ps
module lcd_dual_scan_refresh
  import lcd_scan_pkg::*;
#(
  parameter int CHARS_PER_LINE  = 160,
  parameter int LINES_PER_FRAME = 240,
  parameter int ADDR_W          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_rd_o,
  input  logic [BYTE_W-1:0] sram_rdata_i,
  output logic              shift_clk_o,
  output logic              lp_o,
  output logic              fp_o,
  output logic [NIB_W-1:0]  upper_nib_o,
  output logic [NIB_W-1:0]  lower_nib_o
);
  localparam int HALF_BYTES = CHARS_PER_LINE * LINES_PER_FRAME / 2;

  char_phase_e ph;
  logic        char_tick;

  lcd_char_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_o        (ph),
    .char_tick_o (char_tick),
    .shift_clk_o (shift_clk_o)
  );

  lcd_scan_timing #(
    .CHARS_PER_LINE  (CHARS_PER_LINE),
    .LINES_PER_FRAME (LINES_PER_FRAME)
  ) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_tick_i (char_tick),
    .lp_o        (lp_o),
    .fp_o        (fp_o)
  );

  lcd_pair_fetch #(
    .HALF_BYTES (HALF_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph),
    .char_tick_i (char_tick),
    .rdata_i     (sram_rdata_i),
    .addr_o      (sram_addr_o),
    .rd_o        (sram_rd_o),
    .upper_nib_o (upper_nib_o),
    .lower_nib_o (lower_nib_o)
  );
endmodule

// File: tb/test_lcd_dual_scan_refresh.sv
`timescale 1ns/1ps
module test_lcd_dual_scan_refresh;
  localparam int CPL  = 3;
  localparam int LPF  = 4;
  localparam int HALF = CPL * LPF / 2;
  localparam int AW   = 4;
  localparam int MEMN = 2 * HALF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          rd;
  logic [7:0]    rdata;
  logic          sclk, lp, fp;
  logic [3:0]    un, ln;
  logic [7:0]    mem [MEMN];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  always_comb rdata = (int'(addr) < MEMN) ? mem[addr] : 8'h00;

  lcd_dual_scan_refresh #(
    .CHARS_PER_LINE  (CPL),
    .LINES_PER_FRAME (LPF),
    .ADDR_W          (AW)
  ) i_lcd_dual_scan_refresh (
    .clk          (clk),
    .rst_n        (rst_n),
    .sram_addr_o  (addr),
    .sram_rd_o    (rd),
    .sram_rdata_i (rdata),
    .shift_clk_o  (sclk),
    .lp_o         (lp),
    .fp_o         (fp),
    .upper_nib_o  (un),
    .lower_nib_o  (ln)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_nib(int k, bit upper);
    int j;
    logic [7:0] b;
    if (k == 0) return 0;
    j = ((k - 1) / 2) % HALF;
    b = upper ? mem[j] : mem[j + HALF];
    return (k % 2 == 1) ? int'(b[7:4]) : int'(b[3:0]);
  endfunction

  task automatic check_reset_state(string req);
    chk(req, "lp", int'(lp), 0);
    chk(req, "fp", int'(fp), 0);
    chk(req, "shift clk", int'(sclk), 0);
    chk(req, "strobe", int'(rd), 0);
    chk(req, "addr", int'(addr), 0);
    chk(req, "upper nib", int'(un), 0);
    chk(req, "lower nib", int'(ln), 0);
  endtask

  task automatic check_cycle(int c);
    int k  = c / 4;
    int ph = c % 4;
    bit lp_e = (k % CPL) == CPL - 1;
    chk("R2", "shift clk", int'(sclk), int'(ph >= 2));
    chk("R3", "lp", int'(lp), int'(lp_e));
    chk("R4", "fp", int'(fp), int'(lp_e && ((k / CPL) % LPF) == LPF - 1));
    chk("R5", "strobe", int'(rd), int'((k % 2 == 0) && (ph == 1 || ph == 2)));
    if (k % 2 == 0 && ph == 1) chk("R7", "upper addr", int'(addr), (k / 2) % HALF);
    if (k % 2 == 0 && ph == 2) chk("R8", "lower addr", int'(addr), (k / 2) % HALF + HALF);
    chk("R6", "upper nib", int'(un), exp_nib(k, 1'b1));
    chk("R6", "lower nib", int'(ln), exp_nib(k, 1'b0));
  endtask

  task automatic run(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      check_cycle(c);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // asynchronous assertion at a random point inside a cycle (R9)
  task automatic mid_reset();
    @(posedge clk);
    #(1 + $urandom % 6);
    rst_n = 1'b0;
    #1;
    check_reset_state("R9");
    repeat (2 + $urandom % 3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    for (int i = 0; i < MEMN; i++) mem[i] = {4'(i), 4'(15 - i)};
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    // directed: three full frames, covers pointer wrap (R7) and FP (R4)
    run(3 * 4 * CPL * LPF + 5);

    // directed corner: alternating nibble patterns, reset mid-run
    mid_reset();
    for (int i = 0; i < MEMN; i++) mem[i] = (i % 2 == 0) ? 8'hF0 : 8'h0F;
    rst_n = 1'b1;
    run(60);

    // random contents and random run lengths with mid-period resets
    for (int r = 0; r < 5; r++) begin
      mid_reset();
      for (int i = 0; i < MEMN; i++) mem[i] = 8'($urandom);
      rst_n = 1'b1;
      run(20 + $urandom % 150);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule